// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Master Carrier Timer

This block makes center-aligned PWM for motor drives. A triangular carrier is built from one master interval timer and feeds up to six slave channels. The master counts down from a period value, one step per count-clock tick. Each time it passes zero it flips the carrier direction. A carrier therefore has a falling half and a rising half, each (period + 1) ticks long, and a full carrier lasts 2 × (period + 1) ticks.

Each slave holds a 16-bit up/down counter. The counter starts at that slave's duty value and follows the master direction: it falls through zero and wraps below it during the falling half, then climbs back during the rising half. The slave output is set where the counter hits zero on the way down and cleared where it hits zero on the way up. The pulse is therefore symmetric about the carrier trough. A new duty value is taken only at the carrier crest.

All counting is gated by a single count-clock enable. A start pulse arms the block and a stop pulse returns every output to its default level.

Top module: `cpwm_gen`

## Requirements
- R1: While reset or idle, `slv_out_o` and both interrupt outputs are 0, and `mst_out_o` equals the inverse of `mode_i` (mode 0 gives level 1, mode 1 gives level 0).
- R2: On the first tick after `start_i`, the master counter loads `period_i` and each slave loads its duty value. After that, `mst_irq_o` is high during every tick at which the master counter is 0, which happens once every P ticks (P = `period_i` + 1).
- R3: `mst_out_o` toggles on each tick at which the master counter is 0. The first half after start is the falling half, during which `mst_out_o` sits at its default level, so one carrier lasts 2P ticks and `mst_out_o` spends P of them high.
- R4: A slave output goes to 1 on the tick at which its counter is 0 while falling, and goes to 0 on the tick at which it is 0 while rising. For 1 ≤ D < P this gives 2P − 2D high ticks per carrier.
- R5: Duty D = 0 keeps the slave output at 1 for the whole carrier. D ≥ P keeps it at 0.
- R6: A slave samples its duty value only at the load tick and at the crest tick (master counter 0 in the rising half). A duty change at any other time takes effect from the next carrier.
- R7: With `tick_i` low, no counter, output or interrupt changes, and both interrupt outputs stay 0.
- R8: `stop_i` has priority over `start_i` and `tick_i`. From the next clock it restores the idle levels of R1, and counting stays halted until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one clock wide per count step |
| start_i | input | 1 | Arm and (re)start all channels |
| stop_i | input | 1 | Halt all channels, outputs to default |
| mode_i | input | 1 | Master default level select (0: high first, 1: low first) |
| period_i | input | 16 | Master period value (half-carrier = value + 1 ticks) |
| duty_i | input | 96 | Slave duty values, slave n at bits [16n+15:16n] |
| mst_irq_o | output | 1 | Master counter at zero on this tick |
| mst_out_o | output | 1 | Carrier direction output |
| slv_irq_o | output | 6 | Slave counter at zero on this tick, one bit per slave |
| slv_out_o | output | 6 | Slave PWM outputs, active high |

## Verification
A corrupted master counter or direction flag appears at once at `mst_out_o`. It shows as a half-carrier of the wrong length, or a toggle at a tick with no master interrupt, and in either case it also shifts every slave's high count within the same carrier. A wrong slave counter value moves the zero crossing. That shows as a pulse edge with no interrupt on the tick before it, or as a high count that differs from 2P − 2D within one carrier. A missed or extra duty reload shows one carrier later, as that channel's width taking the wrong duty. Each run is measured over whole carriers, so an error of one tick in any edge changes a count.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/cpwm_master.sv
module cpwm_master
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             ld_o,
  output logic             adv_o,
  output dir_e             dir_o,
  output logic             crest_o,
  output logic             irq_o,
  output logic             out_o
);
  logic             run_q, loaded_q, out_q;
  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;
  logic             zero;

  assign zero    = (cnt_q == '0);
  assign ld_o    = tick_i & run_q & ~loaded_q & ~start_i & ~stop_i;
  assign adv_o   = tick_i & loaded_q & ~start_i & ~stop_i;
  assign irq_o   = adv_o & zero;
  assign crest_o = irq_o & (dir_q == DIR_UP);
  assign dir_o   = dir_q;
  assign out_o   = run_q ? out_q : ~mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      out_q    <= 1'b1;
      cnt_q    <= '0;
      dir_q    <= DIR_DOWN;
    end else if (stop_i) begin
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
    end else if (start_i) begin
      run_q    <= 1'b1;
      loaded_q <= 1'b0;
      dir_q    <= DIR_DOWN;
      out_q    <= ~mode_i;
    end else if (ld_o) begin
      cnt_q    <= period_i;
      loaded_q <= 1'b1;
    end else if (adv_o) begin
      if (zero) begin
        cnt_q <= period_i;
        dir_q <= (dir_q == DIR_DOWN) ? DIR_UP : DIR_DOWN;
        out_q <= ~out_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpwm_slave.sv
module cpwm_slave
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             ld_i,
  input  logic             adv_i,
  input  dir_e             dir_i,
  input  logic             crest_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             irq_o,
  output logic             out_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero  = (cnt_q == '0);
  assign irq_o = adv_i & zero;

  // counter wraps below zero in the falling half; crest reloads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (stop_i || start_i) begin
      out_o <= 1'b0;
    end else if (ld_i) begin
      cnt_q <= duty_i;
    end else if (adv_i) begin
      if (zero) out_o <= (dir_i == DIR_DOWN);
      if (crest_i)                cnt_q <= duty_i;
      else if (dir_i == DIR_DOWN) cnt_q <= cnt_q - 1'b1;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SLV = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   mode_i,
  input  logic [CNT_W-1:0]       period_i,
  input  logic [N_SLV*CNT_W-1:0] duty_i,
  output logic                   mst_irq_o,
  output logic                   mst_out_o,
  output logic [N_SLV-1:0]       slv_irq_o,
  output logic [N_SLV-1:0]       slv_out_o
);
  logic ld, adv, crest;
  dir_e dir;

  cpwm_master #(.CNT_W(CNT_W)) u_master (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mode_i   (mode_i),
    .period_i (period_i),
    .ld_o     (ld),
    .adv_o    (adv),
    .dir_o    (dir),
    .crest_o  (crest),
    .irq_o    (mst_irq_o),
    .out_o    (mst_out_o)
  );

  for (genvar g = 0; g < N_SLV; g++) begin : g_slv
    cpwm_slave #(.CNT_W(CNT_W)) u_slave (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .stop_i  (stop_i),
      .ld_i    (ld),
      .adv_i   (adv),
      .dir_i   (dir),
      .crest_i (crest),
      .duty_i  (duty_i[g*CNT_W +: CNT_W]),
      .irq_o   (slv_irq_o[g]),
      .out_o   (slv_out_o[g])
    );
  end
endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk #(
  parameter int CNT_W = 16,
  parameter int N_SLV = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   tick_i,
  input logic                   start_i,
  input logic                   stop_i,
  input logic                   mode_i,
  input logic [CNT_W-1:0]       period_i,
  input logic [N_SLV*CNT_W-1:0] duty_i,
  input logic                   mst_irq_o,
  input logic                   mst_out_o,
  input logic [N_SLV-1:0]       slv_irq_o,
  input logic [N_SLV-1:0]       slv_out_o
);
  // R7
  mst_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_irq_o |-> tick_i);

  // R7
  slv_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slv_irq_o) |-> tick_i);

  // R3
  mst_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_irq_o && !stop_i && !start_i) |=> (mst_out_o != $past(mst_out_o)));

  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (mst_out_o == !mode_i) && (slv_out_o == '0) && !mst_irq_o);

  for (genvar g = 0; g < N_SLV; g++) begin : g_chk
    // R4
    slv_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(slv_out_o[g]) |-> $past(slv_irq_o[g]));

    // R4
    slv_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(slv_out_o[g]) |-> ($past(slv_irq_o[g]) || $past(stop_i) || $past(start_i)));
  end
endmodule

bind cpwm_gen cpwm_gen_chk #(.CNT_W(CNT_W), .N_SLV(N_SLV)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .start_i   (start_i),
  .stop_i    (stop_i),
  .mode_i    (mode_i),
  .period_i  (period_i),
  .duty_i    (duty_i),
  .mst_irq_o (mst_irq_o),
  .mst_out_o (mst_out_o),
  .slv_irq_o (slv_irq_o),
  .slv_out_o (slv_out_o)
);

// File: tb/cpwm_gen_bench.sv
module cpwm_gen_bench;
  localparam int CNT_W = 16;
  localparam int N_SLV = 6;
  localparam int NV    = 4;

  localparam logic [CNT_W-1:0] PER_V  [NV] = '{16'd7, 16'd0, 16'd19, 16'd4};
  localparam logic             MODE_V [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [CNT_W-1:0] DUTY_V [NV][N_SLV] = '{
    '{16'd0, 16'd1,  16'd2,  16'd4,  16'd7,   16'd8},
    '{16'd0, 16'd1,  16'd2,  16'd0,  16'd1,   16'd5},
    '{16'd3, 16'd10, 16'd19, 16'd20, 16'd100, 16'd16},
    '{16'd1, 16'd2,  16'd3,  16'd4,  16'd5,   16'd0}
  };

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   tick_i = 1'b0;
  logic                   start_i = 1'b0;
  logic                   stop_i = 1'b0;
  logic                   mode_i = 1'b0;
  logic [CNT_W-1:0]       period_i = '0;
  logic [N_SLV*CNT_W-1:0] duty_i = '0;
  logic                   mst_irq_o, mst_out_o;
  logic [N_SLV-1:0]       slv_irq_o, slv_out_o;

  int  n_chk = 0;
  int  n_bad = 0;
  logic tick_en = 1'b0;
  logic slow = 1'b0;
  logic [1:0] ph = '0;

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    tick_i <= slow ? (ph == 2'd2) : tick_en;
    ph     <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
  end

  cpwm_gen #(.CNT_W(CNT_W), .N_SLV(N_SLV)) u_cpwm_gen (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i), .start_i (start_i),
    .stop_i (stop_i), .mode_i (mode_i), .period_i (period_i), .duty_i (duty_i),
    .mst_irq_o (mst_irq_o), .mst_out_o (mst_out_o),
    .slv_irq_o (slv_irq_o), .slv_out_o (slv_out_o)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_hi(input int p, input int d);
    if (d == 0) return 2 * p;
    if (d >= p) return 0;
    return 2 * p - 2 * d;
  endfunction

  // start pulse; returns at the negedge after the load edge
  task automatic do_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int hi [N_SLV];
    int mhi, mirq, p;
    logic first_lvl;
    logic [N_SLV-1:0] snap_o;
    logic snap_m;
    int irq_seen;

    // R1: reset levels for both mode values
    mode_i = 1'b0;
    #23;
    chk(mst_out_o == 1'b1, "R1 mst_out mode0", mst_out_o, 1);
    chk(slv_out_o == '0, "R1 slv_out", slv_out_o, 0);
    chk(!mst_irq_o && slv_irq_o == '0, "R1 irqs", {mst_irq_o, slv_irq_o}, 0);
    mode_i = 1'b1;
    #1;
    chk(mst_out_o == 1'b0, "R1 mst_out mode1", mst_out_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    tick_en = 1'b1;

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      period_i = PER_V[v];
      mode_i   = MODE_V[v];
      for (int s = 0; s < N_SLV; s++) duty_i[s*CNT_W +: CNT_W] = DUTY_V[v][s];
      p = int'(PER_V[v]) + 1;
      do_start();
      for (int s = 0; s < N_SLV; s++) hi[s] = 0;
      mhi = 0; mirq = 0; first_lvl = 1'b0;
      for (int k = 0; k < 2 * p; k++) begin
        @(posedge clk_i); @(negedge clk_i);
        if (k == 0) first_lvl = mst_out_o;
        mhi  += int'(mst_out_o);
        mirq += int'(mst_irq_o);
        for (int s = 0; s < N_SLV; s++) hi[s] += int'(slv_out_o[s]);
      end
      for (int s = 0; s < N_SLV; s++)
        chk(hi[s] == exp_hi(p, int'(DUTY_V[v][s])), "R4 R5 slave high ticks",
            hi[s], exp_hi(p, int'(DUTY_V[v][s])));
      chk(mhi == p, "R3 master high ticks", mhi, p);
      chk(first_lvl == ((p == 1) ? MODE_V[v] : !MODE_V[v]), "R3 master start level",
          first_lvl, (p == 1) ? MODE_V[v] : !MODE_V[v]);
      chk(mirq == 2, "R2 master irq per carrier", mirq, 2);
    end

    // R6: duty change mid-carrier waits for the crest
    period_i = 16'd7; mode_i = 1'b0; p = 8;
    duty_i[0 +: CNT_W] = 16'd2;
    do_start();
    hi[0] = 0;
    for (int k = 0; k < 2 * p; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      if (k == 0) duty_i[0 +: CNT_W] = 16'd6;
      hi[0] += int'(slv_out_o[0]);
    end
    chk(hi[0] == 12, "R6 old duty kept", hi[0], 12);
    hi[0] = 0;
    for (int k = 0; k < 2 * p; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      hi[0] += int'(slv_out_o[0]);
    end
    chk(hi[0] == 4, "R6 new duty at crest", hi[0], 4);

    // R7: sparse ticks stretch widths by the tick spacing
    for (int s = 0; s < N_SLV; s++) duty_i[s*CNT_W +: CNT_W] = DUTY_V[0][s];
    slow = 1'b1;
    do_start();
    repeat (10) @(negedge clk_i);
    for (int s = 0; s < N_SLV; s++) hi[s] = 0;
    for (int k = 0; k < 6 * p; k++) begin
      @(negedge clk_i);
      for (int s = 0; s < N_SLV; s++) hi[s] += int'(slv_out_o[s]);
    end
    for (int s = 0; s < N_SLV; s++)
      chk(hi[s] == 3 * exp_hi(p, int'(DUTY_V[0][s])), "R7 sparse tick width",
          hi[s], 3 * exp_hi(p, int'(DUTY_V[0][s])));
    slow = 1'b0;

    // R7: tick held low freezes everything
    tick_en = 1'b1;
    do_start();
    repeat (5) @(negedge clk_i);
    tick_en = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    snap_o = slv_out_o; snap_m = mst_out_o; irq_seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      if (mst_irq_o || slv_irq_o != '0 || slv_out_o != snap_o || mst_out_o != snap_m)
        irq_seen++;
    end
    chk(irq_seen == 0, "R7 frozen without tick", irq_seen, 0);

    // R8: stop restores idle levels and halts
    tick_en = 1'b1;
    repeat (3) @(negedge clk_i);
    stop_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0; start_i = 1'b0;
    chk(slv_out_o == '0, "R8 slaves idle", slv_out_o, 0);
    chk(mst_out_o == 1'b1, "R8 master default", mst_out_o, 1);
    irq_seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      if (mst_irq_o || slv_irq_o != '0 || slv_out_o != '0 || mst_out_o != 1'b1) irq_seen++;
    end
    chk(irq_seen == 0, "R8 halted after stop", irq_seen, 0);
    mode_i = 1'b1;
    #1;
    chk(mst_out_o == 1'b0, "R1 idle follows mode", mst_out_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule